// File: doc/BRIEF.md
# Register Rename Unit with Retirement Map

This block gives physical names to the architectural registers of an out-of-order core whose results live only in a physical register file. It keeps two tables and a pool. A speculative map translates the operands of instructions as they are dispatched. A retirement map records the bindings of instructions that have committed. A free pool tracks the physical registers that are not in use.

Each dispatched instruction reads its two source registers through the speculative map. If it writes a register, it takes a fresh physical register from the pool. The unit also reports the physical register that the new one replaces. At commit, the retirement map takes the committing binding. The physical register it held before for that architectural register goes back to the pool. When a branch turns out to be mispredicted, the speculative map is replaced with a copy of the retirement map. The pool is then rebuilt from the registers that the retirement map does not reference.

Architectural register 0 always reads as physical register 0 and is never renamed. All lookups are combinational. Every table and pool update takes effect at the next rising clock edge.

Top module: `rn_rename_unit`

## Requirements
- R1: After reset, architectural register i maps to physical register i in both maps. Physical registers 8 to 15 are free. The first allocation returns P8.
- R2: `disp_tag_a`, `disp_tag_b` and `disp_old_tag` show, in the same cycle, the speculative mapping of `disp_src_a`, `disp_src_b` and `disp_dst`. Sources use the mapping from before the instruction's own destination update, even when a source equals the destination.
- R3: An accepted dispatch with a nonzero destination takes the lowest-numbered free physical register, reported on `disp_new_tag`. From the next cycle, the destination maps to that register.
- R4: `disp_stall` is 1 exactly when `disp_valid` is 1, `disp_dst` is nonzero and no physical register is free. A stalled dispatch changes neither the map nor the pool.
- R5: A retire (`ret_valid`, `ret_areg`, `ret_ptag`) writes `ret_ptag` into the retirement map. It frees the physical register the retirement map held for `ret_areg` before, which can be allocated from the next cycle.
- R6: Architectural register 0 always maps to P0. A dispatch with destination 0 allocates nothing, never stalls, and reports 0 on `disp_new_tag` and `disp_old_tag`. A retire to register 0 frees nothing.
- R7: When `mispredict` is 1, the speculative map becomes the retirement map, including a retire presented in the same cycle. The free pool becomes exactly the registers that the map does not reference.
- R8: A dispatch presented in the same cycle as `mispredict` is discarded and allocates nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | Dispatch request this cycle |
| disp_src_a | input | 3 | First source architectural register |
| disp_src_b | input | 3 | Second source architectural register |
| disp_dst | input | 3 | Destination architectural register (0 = none) |
| disp_tag_a | output | 4 | Physical register of first source |
| disp_tag_b | output | 4 | Physical register of second source |
| disp_new_tag | output | 4 | Physical register allocated to destination |
| disp_old_tag | output | 4 | Physical register being replaced |
| disp_stall | output | 1 | Dispatch cannot be accepted (pool empty) |
| ret_valid | input | 1 | Commit of one instruction |
| ret_areg | input | 3 | Committing architectural destination |
| ret_ptag | input | 4 | Committing physical register |
| mispredict | input | 1 | Restore speculative state from retirement map |

## Verification
The tag and stall outputs are combinational. The bench samples them one nanosecond after it drives inputs on the falling edge, in the same cycle as the stimulus. Map, pool and restore effects appear one rising edge later. Each scenario therefore advances exactly one edge and then reads the new state back through lookups and allocations on the next falling edge. Freed registers are only ever expected on the cycle after the retire.

// File: rtl/rn_pkg.sv
package rn_pkg;
  parameter int RN_NUM_AREG = 8;
  parameter int RN_NUM_PREG = 16;
  localparam int RN_AREG_W = $clog2(RN_NUM_AREG);
  localparam int RN_PREG_W = $clog2(RN_NUM_PREG);
endpackage

// File: rtl/rn_map_table.sv
module rn_map_table #(
  parameter int N_ENT = 8,
  parameter int W     = 4,
  localparam int IW   = $clog2(N_ENT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IW-1:0]    wr_idx,
  input  logic [W-1:0]     wr_data,
  input  logic             load_en,
  input  logic [N_ENT*W-1:0] load_data,
  output logic [N_ENT*W-1:0] contents
);
  logic [W-1:0] ent_q [N_ENT];
  logic [W-1:0] ent_d [N_ENT];

  always_comb begin
    for (int i = 0; i < N_ENT; i++) begin
      ent_d[i] = ent_q[i];
      if (load_en)
        ent_d[i] = load_data[i*W +: W];
      else if (wr_en && (wr_idx == IW'(i)) && (i != 0))
        ent_d[i] = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_ENT; i++) ent_q[i] <= W'(i);
    end else if (load_en || wr_en) begin
      for (int i = 0; i < N_ENT; i++) ent_q[i] <= ent_d[i];
    end
  end

  genvar g;
  generate
    for (g = 0; g < N_ENT; g++) begin : g_flat
      assign contents[g*W +: W] = ent_q[g];
    end
  endgenerate
endmodule

// File: rtl/rn_free_pool.sv
module rn_free_pool #(
  parameter int N_PREG  = 16,
  parameter int N_RESET = 8,
  localparam int PW     = $clog2(N_PREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_en,
  input  logic              free_en,
  input  logic [PW-1:0]     free_tag,
  input  logic              rebuild_en,
  input  logic [N_PREG-1:0] rebuild_mask,
  output logic [PW-1:0]     alloc_tag,
  output logic              empty,
  output logic [N_PREG-1:0] free_vec
);
  logic [N_PREG-1:0] free_q, free_d;

  always_comb begin
    alloc_tag = '0;
    for (int i = N_PREG - 1; i >= 0; i--)
      if (free_q[i]) alloc_tag = PW'(i);
  end

  assign empty    = ~|free_q;
  assign free_vec = free_q;

  always_comb begin
    free_d = free_q;
    if (rebuild_en) begin
      free_d = rebuild_mask;
    end else begin
      if (free_en)  free_d[free_tag]  = 1'b1;
      if (alloc_en) free_d[alloc_tag] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_PREG; i++) free_q[i] <= (i >= N_RESET);
    end else if (rebuild_en || free_en || alloc_en) begin
      free_q <= free_d;
    end
  end
endmodule

// File: rtl/rn_rename_unit.sv
module rn_rename_unit
  import rn_pkg::*;
#(
  parameter int NA = RN_NUM_AREG,
  parameter int NP = RN_NUM_PREG,
  localparam int AW = $clog2(NA),
  localparam int PW = $clog2(NP)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          disp_valid,
  input  logic [AW-1:0] disp_src_a,
  input  logic [AW-1:0] disp_src_b,
  input  logic [AW-1:0] disp_dst,
  output logic [PW-1:0] disp_tag_a,
  output logic [PW-1:0] disp_tag_b,
  output logic [PW-1:0] disp_new_tag,
  output logic [PW-1:0] disp_old_tag,
  output logic          disp_stall,
  input  logic          ret_valid,
  input  logic [AW-1:0] ret_areg,
  input  logic [PW-1:0] ret_ptag,
  input  logic          mispredict
);
  logic [NA*PW-1:0] spec_flat, rrat_flat, rrat_after;
  logic [NP-1:0]    free_vec, ref_mask;
  logic [PW-1:0]    alloc_tag, ret_old;
  logic             pool_empty, has_dst, alloc_fire, ret_fire;

  assign has_dst    = (disp_dst != '0);
  assign disp_stall = disp_valid && has_dst && pool_empty;
  assign alloc_fire = disp_valid && has_dst && !pool_empty && !mispredict;
  assign ret_fire   = ret_valid && (ret_areg != '0);

  assign disp_tag_a   = spec_flat[disp_src_a*PW +: PW];
  assign disp_tag_b   = spec_flat[disp_src_b*PW +: PW];
  assign disp_old_tag = has_dst ? spec_flat[disp_dst*PW +: PW] : '0;
  assign disp_new_tag = has_dst ? alloc_tag : '0;
  assign ret_old      = rrat_flat[ret_areg*PW +: PW];

  always_comb begin
    rrat_after = rrat_flat;
    if (ret_fire) rrat_after[ret_areg*PW +: PW] = ret_ptag;
  end

  always_comb begin
    ref_mask = '0;
    for (int i = 0; i < NA; i++) ref_mask[rrat_after[i*PW +: PW]] = 1'b1;
  end

  rn_map_table #(.N_ENT(NA), .W(PW)) spec_map_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(alloc_fire), .wr_idx(disp_dst), .wr_data(alloc_tag),
    .load_en(mispredict), .load_data(rrat_after),
    .contents(spec_flat)
  );

  rn_map_table #(.N_ENT(NA), .W(PW)) rrat_map_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(ret_fire), .wr_idx(ret_areg), .wr_data(ret_ptag),
    .load_en(1'b0), .load_data(rrat_flat),
    .contents(rrat_flat)
  );

  rn_free_pool #(.N_PREG(NP), .N_RESET(NA)) pool_i (
    .clk(clk), .rst_n(rst_n),
    .alloc_en(alloc_fire),
    .free_en(ret_fire && !mispredict), .free_tag(ret_old),
    .rebuild_en(mispredict), .rebuild_mask(~ref_mask),
    .alloc_tag(alloc_tag), .empty(pool_empty), .free_vec(free_vec)
  );
endmodule

// File: rtl/rn_rename_chk.sv
module rn_rename_chk #(
  parameter int NA = 8,
  parameter int NP = 16,
  localparam int AW = $clog2(NA),
  localparam int PW = $clog2(NP)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             disp_valid,
  input logic [AW-1:0]    disp_dst,
  input logic [AW-1:0]    disp_src_a,
  input logic [PW-1:0]    disp_tag_a,
  input logic [PW-1:0]    disp_new_tag,
  input logic [PW-1:0]    disp_old_tag,
  input logic             disp_stall,
  input logic             mispredict,
  input logic             alloc_fire,
  input logic [NP-1:0]    free_vec,
  input logic [NA*PW-1:0] spec_flat,
  input logic [NA*PW-1:0] rrat_after
);
  a_r3_alloc_from_pool: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire |-> (free_vec[disp_new_tag] && disp_new_tag != disp_old_tag));

  a_r4_stall_keeps_map: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_stall && !mispredict) |=> $stable(spec_flat));

  a_r6_zero_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_src_a == '0) |-> (disp_tag_a == '0));

  a_r7_restore_map: assert property (@(posedge clk) disable iff (!rst_n)
    mispredict |=> (spec_flat == $past(rrat_after)));

  a_r7_pool_count: assert property (@(posedge clk) disable iff (!rst_n)
    mispredict |=> ($countones(free_vec) == NP - NA));

  a_r8_no_fire_on_squash: assert property (@(posedge clk) disable iff (!rst_n)
    mispredict |-> !alloc_fire);
endmodule

bind rn_rename_unit rn_rename_chk #(.NA(NA), .NP(NP)) chk_i (
  .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_dst(disp_dst),
  .disp_src_a(disp_src_a), .disp_tag_a(disp_tag_a),
  .disp_new_tag(disp_new_tag), .disp_old_tag(disp_old_tag),
  .disp_stall(disp_stall), .mispredict(mispredict), .alloc_fire(alloc_fire),
  .free_vec(free_vec), .spec_flat(spec_flat), .rrat_after(rrat_after)
);

// File: tb/rn_rename_unit_tb_top.sv
`timescale 1ns/1ps
module rn_rename_unit_tb_top;
  logic       clk, rst_n;
  logic       disp_valid, ret_valid, mispredict;
  logic [2:0] disp_src_a, disp_src_b, disp_dst, ret_areg;
  logic [3:0] disp_tag_a, disp_tag_b, disp_new_tag, disp_old_tag, ret_ptag;
  logic       disp_stall;
  int         n_run, n_fail;
  bit         done;

  rn_rename_unit dut_i (
    .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid),
    .disp_src_a(disp_src_a), .disp_src_b(disp_src_b), .disp_dst(disp_dst),
    .disp_tag_a(disp_tag_a), .disp_tag_b(disp_tag_b),
    .disp_new_tag(disp_new_tag), .disp_old_tag(disp_old_tag),
    .disp_stall(disp_stall), .ret_valid(ret_valid), .ret_areg(ret_areg),
    .ret_ptag(ret_ptag), .mispredict(mispredict)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle();
    disp_valid = 0; disp_src_a = 0; disp_src_b = 0; disp_dst = 0;
    ret_valid = 0; ret_areg = 0; ret_ptag = 0; mispredict = 0;
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk); idle(); #1;
  endtask

  task automatic disp(logic [2:0] a, logic [2:0] b, logic [2:0] d);
    disp_valid = 1; disp_src_a = a; disp_src_b = b; disp_dst = d; #1;
  endtask

  task automatic lookup(int r, int exp, string req);
    disp_src_a = 3'(r); #1;
    chk(req, disp_tag_a, exp);
  endtask

  task automatic t_reset();
    for (int i = 0; i < 8; i++) lookup(i, i, "R1 reset map");
    disp(0, 0, 1);
    chk("R1 first alloc", disp_new_tag, 8);
    chk("R1 no stall", disp_stall, 0);
    idle(); #1;
  endtask

  task automatic t_example();
    disp(2, 3, 1);
    chk("R2 src a", disp_tag_a, 2);
    chk("R2 src b", disp_tag_b, 3);
    chk("R3 new", disp_new_tag, 8);
    chk("R2 old", disp_old_tag, 1);
    tick();
    disp(1, 3, 3);
    chk("R3 remap visible", disp_tag_a, 8);
    chk("R2 src b", disp_tag_b, 3);
    chk("R3 new", disp_new_tag, 9);
    chk("R2 old", disp_old_tag, 3);
    tick();
    disp(2, 2, 2);
    chk("R2 src equals dst", disp_tag_a, 2);
    chk("R3 new", disp_new_tag, 10);
    tick();
    lookup(2, 10, "R3 remap R2");
    disp(0, 0, 0);
    chk("R6 dst0 new", disp_new_tag, 0);
    chk("R6 dst0 old", disp_old_tag, 0);
    tick();
    disp(0, 0, 6);
    chk("R6 dst0 allocated nothing", disp_new_tag, 11);
    idle(); #1;
  endtask

  task automatic t_exhaust();
    for (int i = 0; i < 5; i++) begin
      disp(0, 0, 4);
      chk("R3 lowest free", disp_new_tag, 11 + i);
      chk("R2 old chain", disp_old_tag, (i == 0) ? 4 : 10 + i);
      tick();
    end
    disp(0, 0, 4);
    chk("R4 stall when empty", disp_stall, 1);
    tick();
    disp(0, 0, 4);
    chk("R4 stalled map unchanged", disp_old_tag, 15);
    disp_dst = 0; #1;
    chk("R6 dst0 never stalls", disp_stall, 0);
    disp_valid = 0; disp_dst = 4; #1;
    chk("R4 no stall without valid", disp_stall, 0);
    idle(); #1;
  endtask

  task automatic t_retire();
    ret_valid = 1; ret_areg = 1; ret_ptag = 8;
    tick();
    disp(0, 0, 5);
    chk("R5 freed reg stall", disp_stall, 0);
    chk("R5 freed reg reused", disp_new_tag, 1);
    tick();
    ret_valid = 1; ret_areg = 0; ret_ptag = 0;
    tick();
    disp(0, 0, 5);
    chk("R6 retire r0 frees none", disp_stall, 1);
    idle(); #1;
  endtask

  task automatic t_mispredict();
    int seq[8] = '{1, 3, 10, 11, 12, 13, 14, 15};
    int expm[8] = '{0, 8, 2, 9, 4, 5, 6, 7};
    mispredict = 1; disp_valid = 1; disp_dst = 6;
    ret_valid = 1; ret_areg = 3; ret_ptag = 9;
    tick();
    for (int i = 0; i < 8; i++) lookup(i, expm[i], "R7 restored map");
    lookup(6, 6, "R8 squashed dispatch");
    for (int i = 0; i < 8; i++) begin
      disp(0, 0, 2);
      chk("R7 rebuilt pool", disp_new_tag, seq[i]);
      tick();
    end
    disp(0, 0, 2);
    chk("R7 pool size", disp_stall, 1);
    idle(); #1;
  endtask

  initial begin
    n_run = 0; n_fail = 0; done = 0;
    idle();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1; #1;
    t_reset();
    t_example();
    t_exhaust();
    t_retire();
    t_mispredict();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule